// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

The walker reads a linked chain of 16-byte region descriptors out of memory and turns each one into a single burst request for a downstream data mover. A start pulse gives it the address of the first descriptor. It fetches that entry as four 32-bit words over a simple one-outstanding read port and presents the buffer address, byte count, direction, ordering hint and transfer mode. It holds the request until the mover takes it, and then follows the entry's own next pointer. A flag in the entry marks the last one, and the walk ends there.

The walk stops early in two cases. An entry whose length word is zero ends it with a zero-length error, and no request is issued for that entry. A chain that has not reached its last entry after `MAX_DESC` transfers ends with an overrun error, so a corrupt chain cannot keep the walker busy for ever. A one-cycle done pulse reports every end of walk. The two error flags keep their values until the next start.

Top module: `sg_chain_walker`

## Requirements
- R1: A `start` pulse while idle begins a walk at `first_addr` with its low 3 bits treated as zero. A `start` pulse while `busy` is high is ignored.
- R2: Each descriptor is read as four little-endian words at offsets +0, +4, +8 and +12 from its base. The word at +0 is the buffer address, +4 is the length in 8-byte units, +8 holds the flags byte in bits 7:0 and the mode byte in bits 15:8, and +12 is the next pointer. Only one read is outstanding at a time, and `rd_req` stays high with a stable `rd_addr` until `rd_valid`.
- R3: `xfer_bytes` equals the length word multiplied by 8.
- R4: Flag bit 4 drives `xfer_ordered`, flag bit 5 drives `xfer_write` (1 = toward the device), and flag bit 7 marks the last descriptor. `xfer_mode` is the low nibble of the mode byte, and its high nibble is ignored.
- R5: Each accepted descriptor produces exactly one request. That request stays valid with all its fields stable until `xfer_ready` is high. No descriptor read overlaps a pending request.
- R6: After a request is taken, the walker fetches the descriptor at the next pointer with its low 3 bits cleared. After the last descriptor it ignores the next pointer, drops `busy` and pulses `done` for one cycle with both error flags low.
- R7: A length word of zero issues no request for that entry and ends the walk with `done` and `err_zero_len` set.
- R8: When `MAX_DESC` requests have been taken and none carried the last flag, the walk ends with `done` and `err_overrun` set. At most one error flag is ever set.
- R9: After reset the block is idle: `busy`, `done`, `rd_req`, `xfer_valid` and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| first_addr | input | 32 | Address of the first descriptor |
| rd_req | output | 1 | Memory read request, held until rd_valid |
| rd_addr | output | 32 | Word address of the read |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Read data word |
| xfer_valid | output | 1 | Burst request pending |
| xfer_addr | output | 32 | Buffer start address |
| xfer_bytes | output | 35 | Burst length in bytes |
| xfer_write | output | 1 | 1 = toward the device |
| xfer_ordered | output | 1 | Ordered-processing hint |
| xfer_mode | output | 4 | Transfer mode |
| xfer_ready | input | 1 | Data mover accepts the request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err_zero_len | output | 1 | Walk ended on a zero length word |
| err_overrun | output | 1 | Walk ended on the chain limit |

## Verification
The assertions assume that memory returns `rd_valid` only while `rd_req` is high and at most once for each request. The bench's memory model meets this because it answers a pending request one cycle later and never twice in a row. The request-hold and overlap properties also assume that the mover raises `xfer_ready` only while it sees a request. The bench's mover drives `xfer_ready` from `xfer_valid` alone, with a programmable delay. That delay is what exercises the hold behaviour.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W    = 32;
  localparam int DESC_WRDS = 4;
  localparam int FLG_ORD   = 4;
  localparam int FLG_WR    = 5;
  localparam int FLG_LAST  = 7;

  typedef struct packed {
    logic [WORD_W-1:0] buf_addr;
    logic [WORD_W-1:0] len_units;
    logic              ordered;
    logic              write;
    logic              last;
    logic [3:0]        mode;
    logic [WORD_W-1:0] next_ptr;
  } desc_t;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK, S_XFER} wstate_t;
endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch #(
  parameter int WW    = 32,
  parameter int WORDS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [WW-1:0]       base,
  output logic                rd_req,
  output logic [WW-1:0]       rd_addr,
  input  logic                rd_valid,
  input  logic [WW-1:0]       rd_data,
  output logic [WORDS*WW-1:0] words_o,
  output logic                fin
);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [WW-1:0] STEP = WW'(WW / 8);

  logic [WW-1:0] wbuf [WORDS];
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
      idx     <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rd_req  <= 1'b1;
        rd_addr <= base;
        idx     <= '0;
      end else if (rd_req && rd_valid) begin
        if (idx == IW'(WORDS - 1)) begin
          rd_req <= 1'b0;
          fin    <= 1'b1;
        end else begin
          idx     <= idx + 1'b1;
          rd_addr <= rd_addr + STEP;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_req && rd_valid) wbuf[idx] <= rd_data;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_out
    assign words_o[g*WW +: WW] = wbuf[g];
  end
endmodule

// File: rtl/sgw_unpack.sv
module sgw_unpack
  import sgw_pkg::*;
(
  input  logic [DESC_WRDS*WORD_W-1:0] words,
  output desc_t                       d
);
  logic [WORD_W-1:0] w_ctl;
  logic              unused_bits;

  assign w_ctl       = words[2*WORD_W +: WORD_W];
  assign d.buf_addr  = words[0 +: WORD_W];
  assign d.len_units = words[WORD_W +: WORD_W];
  assign d.ordered   = w_ctl[FLG_ORD];
  assign d.write     = w_ctl[FLG_WR];
  assign d.last      = w_ctl[FLG_LAST];
  assign d.mode      = w_ctl[11:8];
  assign d.next_ptr  = words[3*WORD_W +: WORD_W];
  assign unused_bits = ^{w_ctl[31:12], w_ctl[6], w_ctl[3:0]};
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int MAX_DESC = 256,
  parameter int LEN_SH   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [WORD_W-1:0]        first_addr,
  output logic                     rd_req,
  output logic [WORD_W-1:0]        rd_addr,
  input  logic                     rd_valid,
  input  logic [WORD_W-1:0]        rd_data,
  output logic                     xfer_valid,
  output logic [WORD_W-1:0]        xfer_addr,
  output logic [WORD_W+LEN_SH-1:0] xfer_bytes,
  output logic                     xfer_write,
  output logic                     xfer_ordered,
  output logic [3:0]               xfer_mode,
  input  logic                     xfer_ready,
  output logic                     busy,
  output logic                     done,
  output logic                     err_zero_len,
  output logic                     err_overrun
);
  localparam int CW = $clog2(MAX_DESC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_DESC);

  wstate_t                      state;
  logic                         fgo;
  logic                         fdone;
  logic [WORD_W-1:0]            fbase;
  logic [DESC_WRDS*WORD_W-1:0]  words;
  desc_t                        d;
  logic [CW-1:0]                cnt;

  sgw_fetch #(.WW(WORD_W), .WORDS(DESC_WRDS)) u_fetch (
    .clk(clk), .rst(rst), .go(fgo), .base(fbase),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .words_o(words), .fin(fdone)
  );

  sgw_unpack u_unpack (.words(words), .d(d));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      busy         <= 1'b0;
      done         <= 1'b0;
      err_zero_len <= 1'b0;
      err_overrun  <= 1'b0;
      xfer_valid   <= 1'b0;
      xfer_addr    <= '0;
      xfer_bytes   <= '0;
      xfer_write   <= 1'b0;
      xfer_ordered <= 1'b0;
      xfer_mode    <= '0;
      fgo          <= 1'b0;
      fbase        <= '0;
      cnt          <= '0;
    end else begin
      done <= 1'b0;
      fgo  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          fbase        <= {first_addr[WORD_W-1:3], 3'b000};
          fgo          <= 1'b1;
          cnt          <= '0;
          err_zero_len <= 1'b0;
          err_overrun  <= 1'b0;
          busy         <= 1'b1;
          state        <= S_FETCH;
        end
        S_FETCH: if (fdone) state <= S_CHECK;
        S_CHECK: begin
          if (d.len_units == '0) begin
            err_zero_len <= 1'b1;
            busy         <= 1'b0;
            done         <= 1'b1;
            state        <= S_IDLE;
          end else begin
            xfer_valid   <= 1'b1;
            xfer_addr    <= d.buf_addr;
            xfer_bytes   <= {d.len_units, LEN_SH'(0)};
            xfer_write   <= d.write;
            xfer_ordered <= d.ordered;
            xfer_mode    <= d.mode;
            cnt          <= cnt + 1'b1;
            state        <= S_XFER;
          end
        end
        S_XFER: if (xfer_ready) begin
          xfer_valid <= 1'b0;
          if (d.last || cnt == CNT_MAX) begin
            err_overrun <= !d.last;
            busy        <= 1'b0;
            done        <= 1'b1;
            state       <= S_IDLE;
          end else begin
            fbase <= {d.next_ptr[WORD_W-1:3], 3'b000};
            fgo   <= 1'b1;
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_chain_walker_sva.sv
module sg_chain_walker_sva #(
  parameter int WW = 32,
  parameter int BW = 35
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_req,
  input logic [WW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          xfer_valid,
  input logic [WW-1:0] xfer_addr,
  input logic [BW-1:0] xfer_bytes,
  input logic          xfer_write,
  input logic          xfer_ordered,
  input logic [3:0]    xfer_mode,
  input logic          xfer_ready,
  input logic          busy,
  input logic          done,
  input logic          err_zero_len,
  input logic          err_overrun
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));
  p_word_align_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> rd_addr[1:0] == 2'b00);
  p_valid_has_req_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_req);
  p_bytes_mult8_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> xfer_bytes[2:0] == 3'b000 && xfer_bytes != '0);
  p_xfer_hold_r5: assert property (@(posedge clk) disable iff (rst)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) &&
      $stable(xfer_bytes) && $stable(xfer_write) &&
      $stable(xfer_ordered) && $stable(xfer_mode));
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    !(xfer_valid && rd_req));
  p_done_ends_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));
  p_one_err_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_zero_len, err_overrun}));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !xfer_valid && !rd_req);
endmodule

bind sg_chain_walker sg_chain_walker_sva #(.WW(sgw_pkg::WORD_W), .BW(sgw_pkg::WORD_W + LEN_SH)) u_sva (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes),
  .xfer_write(xfer_write), .xfer_ordered(xfer_ordered), .xfer_mode(xfer_mode),
  .xfer_ready(xfer_ready), .busy(busy), .done(done),
  .err_zero_len(err_zero_len), .err_overrun(err_overrun)
);

// File: tb/sg_chain_walker_test.sv
module sg_chain_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] first_addr = '0;
  logic        rd_req, rd_valid;
  logic [31:0] rd_addr, rd_data;
  logic        xfer_valid, xfer_write, xfer_ordered;
  logic [31:0] xfer_addr;
  logic [34:0] xfer_bytes;
  logic [3:0]  xfer_mode;
  logic        xfer_ready = 1'b0;
  logic        busy, done, err_zero_len, err_overrun;

  always #2 clk = ~clk;

  sg_chain_walker #(.MAX_DESC(4)) uut (
    .clk(clk), .rst(rst), .start(start), .first_addr(first_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes),
    .xfer_write(xfer_write), .xfer_ordered(xfer_ordered), .xfer_mode(xfer_mode),
    .xfer_ready(xfer_ready), .busy(busy), .done(done),
    .err_zero_len(err_zero_len), .err_overrun(err_overrun)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [31:0] mem [256];
  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_req && !rd_valid;
    rd_data <= mem[rd_addr[9:2]];
  end

  int ready_delay = 0;
  int wcnt = 0;
  always @(negedge clk) begin
    if (xfer_valid) begin
      if (wcnt >= ready_delay) xfer_ready <= 1'b1;
      else wcnt <= wcnt + 1;
    end else begin
      xfer_ready <= 1'b0;
      wcnt <= 0;
    end
  end

  int          nx = 0, nrd = 0, nvalid = 0;
  logic [31:0] lx_addr [8];
  logic [34:0] lx_bytes [8];
  logic        lx_wr [8];
  logic        lx_ord [8];
  logic [3:0]  lx_mode [8];
  logic [31:0] first_rd;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (xfer_valid) nvalid <= nvalid + 1;
    if (rd_req && rd_valid) begin
      if (nrd == 0) first_rd <= rd_addr;
      nrd <= nrd + 1;
    end
    if (xfer_valid && xfer_ready && nx < 8) begin
      lx_addr[nx]  <= xfer_addr;
      lx_bytes[nx] <= xfer_bytes;
      lx_wr[nx]    <= xfer_write;
      lx_ord[nx]   <= xfer_ordered;
      lx_mode[nx]  <= xfer_mode;
      nx <= nx + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int base, input logic [31:0] ba, input logic [31:0] len,
                          input logic [7:0] flg, input logic [7:0] mode, input logic [31:0] nxt);
    mem[base/4]     = ba;
    mem[base/4 + 1] = len;
    mem[base/4 + 2] = {8'h5A, 8'hC3, mode, flg};
    mem[base/4 + 3] = nxt;
  endtask

  task automatic clear_log();
    @(negedge clk);
    nx = 0; nrd = 0; nvalid = 0;
  endtask

  task automatic kick(input logic [31:0] a);
    @(negedge clk);
    first_addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(done, req, done, 1);
  endtask

  task automatic t_reset();
    chk(!busy, "R9", busy, 0);
    chk(!done && !rd_req && !xfer_valid, "R9", {done, rd_req, xfer_valid}, 0);
    chk(!err_zero_len && !err_overrun, "R9", {err_zero_len, err_overrun}, 0);
  endtask

  task automatic t_single();
    put_desc(32'h40, 32'h1000_0000, 5, 8'hB0, 8'hA6, 32'h0000_0100);
    clear_log();
    kick(32'h40);
    wait_done("R6");
    chk(!err_zero_len && !err_overrun, "R6", {err_zero_len, err_overrun}, 0);
    @(negedge clk);
    chk(!done && !busy, "R6", {done, busy}, 0);
    chk(nx == 1, "R6", nx, 1);
    chk(nrd == 4 && first_rd == 32'h40, "R2", first_rd, 32'h40);
    chk(lx_addr[0] == 32'h1000_0000, "R2", lx_addr[0], 32'h1000_0000);
    chk(lx_bytes[0] == 35'd40, "R3", lx_bytes[0], 40);
    chk(lx_wr[0] && lx_ord[0], "R4", {lx_wr[0], lx_ord[0]}, 3);
    chk(lx_mode[0] == 4'h6, "R4", lx_mode[0], 6);
  endtask

  task automatic t_chain();
    put_desc(32'h100, 32'hAAAA_0008, 1,       8'h20, 8'h02, 32'h0000_020B);
    put_desc(32'h208, 32'hBBBB_0000, 32'h100, 8'h10, 8'hF9, 32'h0000_0080);
    put_desc(32'h80,  32'hCCCC_0010, 7,       8'h80, 8'h03, 32'h0000_0100);
    clear_log();
    kick(32'h105);
    wait_done("R6");
    chk(first_rd == 32'h100, "R1", first_rd, 32'h100);
    chk(nx == 3 && nrd == 12, "R6", nx, 3);
    chk(lx_addr[1] == 32'hBBBB_0000 && lx_addr[2] == 32'hCCCC_0010, "R6", lx_addr[1], 32'hBBBB_0000);
    chk(lx_bytes[1] == 35'h800 && lx_bytes[2] == 35'd56, "R3", lx_bytes[1], 35'h800);
    chk(lx_wr[0] && !lx_ord[0] && !lx_wr[1] && lx_ord[1], "R4",
        {lx_wr[0], lx_ord[0], lx_wr[1], lx_ord[1]}, 4'b1001);
    chk(lx_mode[1] == 4'h9, "R4", lx_mode[1], 9);
  endtask

  task automatic t_zero();
    put_desc(32'h300, 32'h2000_0000, 3, 8'h00, 8'h01, 32'h0000_0320);
    put_desc(32'h320, 32'h3000_0000, 0, 8'h80, 8'h01, 32'h0);
    clear_log();
    kick(32'h300);
    wait_done("R7");
    chk(err_zero_len && !err_overrun, "R7", {err_zero_len, err_overrun}, 2);
    chk(nx == 1, "R7", nx, 1);
  endtask

  task automatic t_limit();
    put_desc(32'h380, 32'h4000_0000, 2, 8'h00, 8'h00, 32'h0000_0380);
    clear_log();
    kick(32'h380);
    wait_done("R8");
    chk(err_overrun && !err_zero_len, "R8", {err_zero_len, err_overrun}, 1);
    chk(nx == 4, "R8", nx, 4);
    kick(32'h40);
    wait_done("R8");
    chk(!err_overrun, "R8", err_overrun, 0);
  endtask

  task automatic t_slow();
    ready_delay = 6;
    clear_log();
    kick(32'h40);
    wait_done("R5");
    chk(nx == 1, "R5", nx, 1);
    chk(nvalid == 7, "R5", nvalid, 7);
    ready_delay = 0;
  endtask

  task automatic t_busy_start();
    clear_log();
    kick(32'h100);
    repeat (3) @(negedge clk);
    kick(32'h40);
    wait_done("R1");
    chk(nx == 3 && lx_addr[0] == 32'hAAAA_0008, "R1", lx_addr[0], 32'hAAAA_0008);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_zero();
    t_limit();
    t_slow();
    t_busy_start();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule